// File: doc/BRIEF.md
# Trellis Decoder Status and Metric Initialization Control

This block holds the status and control logic of a trellis (Viterbi-style) decoder coprocessor. A host reads a 16-bit, read-only status word over a simple read port. The word carries three live flags: a metric-initialization flag, a flush-in-progress flag and an operation-complete flag. Every other bit reads as zero.

When initialization is requested, a sequencer writes a start-up path metric to every trellis state, one state per clock. The number of states is 2^(K-1), where K is the configured constraint length. The start-up values are either the same for all states, or they favour one preferred starting state. The flag stays up for exactly one pass over the states.

The operation-complete flag drives a maskable interrupt level. The host clears the flag by acknowledging the interrupt or by writing a mode enable. A separate mode-disable control suppresses the flag altogether. Three reset sources clear every flag. An idle indication clears every flag except the completion flag.

Top module: `trellis_status_ctl`

## Requirements
- R1: The read word has the initialization flag at bit 0, the flush flag at bit 1 and the completion flag at bit 4, and all other bits read zero. `rd_data` shows the word sampled at the edge where `rd_en` is high. `rd_data` is zero one cycle after an edge where `rd_en` is low.
- R2: Any of the following clears every flag, stops metric writes and drops `irq` at the next edge: `rst_n` low, `sw_rst` high or `cop_rst` high.
- R3: While `idle` is high, the initialization and flush flags are held clear and the sequencer stops. The completion flag keeps its value.
- R4: `init_start` is accepted when the sequencer is neither busy nor idle. After the accepting edge, `mem_we` and the initialization flag stay high for exactly 2^(K-1) cycles. During those cycles `mem_addr` counts 0, 1, … up to 2^(K-1)-1, and then both fall.
- R5: K is taken from `cfg_k` at the accepting edge. A value below 5 is treated as 5, and a value above `MAX_K` (default 9) is treated as `MAX_K`.
- R6: With `cfg_pref_en` low, every `mem_wdata` word is 0. With it high, the state equal to `cfg_pref_state` gets 0 and every other state gets `PREF_BIAS` (default 64).
- R7: `flush_start` sets the flush flag and `flush_done` clears it. If both arrive in the same cycle, the flag is cleared.
- R8: `op_done` sets the completion flag. A pulse on any bit of the 5-bit `mode_en_wr` clears it, and the clear wins over a set in the same cycle.
- R9: `irq` is high when the completion flag and `irq_en` are both high. `irq_ack` while `irq` is high clears the flag, so `irq` is low in the next cycle. `irq_ack` while `irq` is low has no effect.
- R10: While `cm_disable` is high, the completion flag is cleared, held clear and `op_done` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| sw_rst | input | 1 | Software reset request |
| cop_rst | input | 1 | Coprocessor-only reset request |
| idle | input | 1 | Coprocessor is in its idle state |
| init_start | input | 1 | Request metric initialization |
| cfg_k | input | 4 | Constraint length K |
| cfg_pref_en | input | 1 | Favour one starting state |
| cfg_pref_state | input | MAX_K-1 | Preferred starting state |
| flush_start | input | 1 | Flush begins |
| flush_done | input | 1 | Flush has finished |
| op_done | input | 1 | Block processed and fully read out |
| mode_en_wr | input | 5 | One-cycle pulses: mode enable bit written to one |
| irq_en | input | 1 | Completion interrupt enable |
| cm_disable | input | 1 | Mode-disable control that suppresses the completion flag |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| rd_en | input | 1 | Status read strobe |
| rd_data | output | 16 | Status word read data |
| irq | output | 1 | Completion interrupt level |
| mem_we | output | 1 | Metric memory write enable |
| mem_addr | output | MAX_K-1 | Metric memory state address |
| mem_wdata | output | METRIC_W | Start-up path metric |

## Verification
The hardest situations to reach are the ones that cut a long initialization pass short. These are an idle indication or a soft reset arriving in the middle of the pass, and a status read taken while the pass is still running.

The bench starts a pass, counts the write cycles it observes, and then either reads the word partway through or raises `idle` a few cycles in. It checks that the writes stop at the next edge and that the completion flag set beforehand survives.

The completion flag's clear rules are walked as a table. Each step carries state into the next, so acknowledge-while-masked, a clear that collides with a set, and the mode-disable hold each follow a known flag value.

// File: rtl/trellis_stat_pkg.sv
// Package: shared constants for the trellis decoder status block.
// Assumes: status word is 16 bits; flag positions are fixed for host software.
package trellis_stat_pkg;
    localparam int STAT_W    = 16;
    localparam int BIT_INIT  = 0;
    localparam int BIT_FLUSH = 1;
    localparam int BIT_DONE  = 4;
    localparam int N_MODES   = 5;
    localparam int MIN_K     = 5;

    typedef struct packed {
        logic done;
        logic flush;
        logic init;
    } stat_flags_t;
endpackage

// File: rtl/metric_init_seq.sv
// Module: metric_init_seq
// Walks every trellis state once, one per clock, writing a start-up path
// metric. Assumes the state count is 2^(K-1) with K clamped to MIN_K..MAX_K,
// and that the configuration is stable only at the accepting edge.
module metric_init_seq #(
    parameter int MAX_K     = 9,
    parameter int MIN_K     = 5,
    parameter int KW        = 4,
    parameter int AW        = MAX_K - 1,
    parameter int MW        = 12,
    parameter int PREF_BIAS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          start,
    input  logic [KW-1:0] cfg_k,
    input  logic          pref_en,
    input  logic [AW-1:0] pref_state,
    output logic          busy,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [MW-1:0] wdata
);
    logic          busy_q;
    logic          pen_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] last_q;
    logic [AW-1:0] pref_q;
    logic [KW-1:0] eff_k;
    logic [AW-1:0] last_c;

    // Clamp the constraint length and derive the final state address.
    always_comb begin
        eff_k = cfg_k;
        if (cfg_k < KW'(MIN_K))
            eff_k = KW'(MIN_K);
        else if (cfg_k > KW'(MAX_K))
            eff_k = KW'(MAX_K);
        last_c = AW'((32'd1 << (32'(eff_k) - 32'd1)) - 32'd1);
    end

    // Address counter: load on start, step each cycle, stop after the last state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            last_q <= '0;
            pref_q <= '0;
            pen_q  <= 1'b0;
        end else if (busy_q) begin
            if (addr_q == last_q) begin
                busy_q <= 1'b0;
                addr_q <= '0;
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end else if (start) begin
            busy_q <= 1'b1;
            addr_q <= '0;
            last_q <= last_c;
            pref_q <= pref_state;
            pen_q  <= pref_en;
        end
    end

    // Write port: favoured state gets zero, others the bias when favouring.
    always_comb begin
        busy  = busy_q;
        we    = busy_q;
        addr  = addr_q;
        wdata = (pen_q && (addr_q != pref_q)) ? MW'(PREF_BIAS) : '0;
    end
endmodule

// File: rtl/done_flag_ctl.sv
// Module: done_flag_ctl
// Holds the operation-complete flag and its interrupt level. Assumes
// mode_wr and ack are single-cycle pulses; clears win over the set.
module done_flag_ctl #(
    parameter int N_MODES = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               cm_disable,
    input  logic [N_MODES-1:0] mode_wr,
    input  logic               op_done,
    input  logic               irq_en,
    input  logic               irq_ack,
    output logic               done,
    output logic               irq
);
    logic done_q;

    // Flag register: reset/disable first, then clear events, then the set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || cm_disable)
            done_q <= 1'b0;
        else if ((|mode_wr) || (irq_ack && irq))
            done_q <= 1'b0;
        else if (op_done)
            done_q <= 1'b1;
    end

    // Interrupt level follows the flag gated by its enable.
    always_comb begin
        done = done_q;
        irq  = done_q && irq_en;
    end
endmodule

// File: rtl/trellis_status_ctl.sv
// Module: trellis_status_ctl
// Status and initialization control for a trellis decoder coprocessor:
// assembles the read-only status word, tracks flush activity, sequences
// metric initialization and raises the completion interrupt.
// Assumes all control inputs are synchronous to clk.
module trellis_status_ctl
    import trellis_stat_pkg::*;
#(
    parameter int MAX_K     = 9,
    parameter int METRIC_W  = 12,
    parameter int PREF_BIAS = 64,
    localparam int AW       = MAX_K - 1,
    localparam int KW       = $clog2(MAX_K + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_rst,
    input  logic                cop_rst,
    input  logic                idle,
    input  logic                init_start,
    input  logic [KW-1:0]       cfg_k,
    input  logic                cfg_pref_en,
    input  logic [AW-1:0]       cfg_pref_state,
    input  logic                flush_start,
    input  logic                flush_done,
    input  logic                op_done,
    input  logic [N_MODES-1:0]  mode_en_wr,
    input  logic                irq_en,
    input  logic                cm_disable,
    input  logic                irq_ack,
    input  logic                rd_en,
    output logic [STAT_W-1:0]   rd_data,
    output logic                irq,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [METRIC_W-1:0] mem_wdata
);
    logic              soft_clr;
    logic              idle_clr;
    logic              flush_q;
    stat_flags_t       flags;
    logic [STAT_W-1:0] stat_word;
    logic [STAT_W-1:0] rd_q;

    // Reset sources clear everything; idle additionally clears busy flags.
    always_comb begin
        soft_clr = sw_rst || cop_rst;
        idle_clr = soft_clr || idle;
    end

    metric_init_seq #(
        .MAX_K     (MAX_K),
        .MIN_K     (MIN_K),
        .KW        (KW),
        .AW        (AW),
        .MW        (METRIC_W),
        .PREF_BIAS (PREF_BIAS)
    ) i_init (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (idle_clr),
        .start      (init_start),
        .cfg_k      (cfg_k),
        .pref_en    (cfg_pref_en),
        .pref_state (cfg_pref_state),
        .busy       (flags.init),
        .we         (mem_we),
        .addr       (mem_addr),
        .wdata      (mem_wdata)
    );

    done_flag_ctl #(
        .N_MODES (N_MODES)
    ) i_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_clr),
        .cm_disable (cm_disable),
        .mode_wr    (mode_en_wr),
        .op_done    (op_done),
        .irq_en     (irq_en),
        .irq_ack    (irq_ack),
        .done       (flags.done),
        .irq        (irq)
    );

    // Flush flag: finish wins over start; idle and resets hold it clear.
    always_ff @(posedge clk) begin
        if (!rst_n || idle_clr)
            flush_q <= 1'b0;
        else if (flush_done)
            flush_q <= 1'b0;
        else if (flush_start)
            flush_q <= 1'b1;
    end

    // Status word assembly with all unused positions tied to zero.
    always_comb begin
        flags.flush         = flush_q;
        stat_word           = '0;
        stat_word[BIT_INIT]  = flags.init;
        stat_word[BIT_FLUSH] = flags.flush;
        stat_word[BIT_DONE]  = flags.done;
    end

    // Registered read port: word on a read strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_en ? stat_word : '0;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/trellis_status_chk.sv
// Module: trellis_status_chk
// Assertion checker bound to trellis_status_ctl. Assumes the same clock
// and active-low synchronous reset as the design.
module trellis_status_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_rst,
    input logic          cop_rst,
    input logic          idle,
    input logic [4:0]    mode_en_wr,
    input logic          cm_disable,
    input logic          irq_ack,
    input logic          flush_done,
    input logic          irq,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [15:0]   rd_data,
    input logic [15:0]   stat_word
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 16'hFFEC) == 16'h0000);

    // R2
    soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst || cop_rst) |=> (stat_word == 16'h0000 && !mem_we && !irq));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (stat_word[1:0] == 2'b00 && !mem_we));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    // R7
    flush_done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !stat_word[1]);

    // R8
    mode_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mode_en_wr) |=> !stat_word[4]);

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> !irq);

    // R10
    disable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_disable |=> (!stat_word[4] && !irq));
endmodule

bind trellis_status_ctl trellis_status_chk #(.AW(AW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .cop_rst    (cop_rst),
    .idle       (idle),
    .mode_en_wr (mode_en_wr),
    .cm_disable (cm_disable),
    .irq_ack    (irq_ack),
    .flush_done (flush_done),
    .irq        (irq),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .rd_data    (rd_data),
    .stat_word  (stat_word)
);

// File: tb/test_trellis_status_ctl.sv
`timescale 1ns/1ps
// Bench for trellis_status_ctl: table walk of completion-flag rules,
// then directed tests for reset, idle, flush and initialization.
module test_trellis_status_ctl;
    logic        clk = 1'b0;
    logic        rst_n, sw_rst, cop_rst, idle, init_start;
    logic [3:0]  cfg_k;
    logic        cfg_pref_en;
    logic [7:0]  cfg_pref_state;
    logic        flush_start, flush_done, op_done;
    logic [4:0]  mode_en_wr;
    logic        irq_en, cm_disable, irq_ack, rd_en;
    logic [15:0] rd_data;
    logic        irq, mem_we;
    logic [7:0]  mem_addr;
    logic [11:0] mem_wdata;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    trellis_status_ctl i_trellis_status_ctl (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cop_rst(cop_rst),
        .idle(idle), .init_start(init_start), .cfg_k(cfg_k),
        .cfg_pref_en(cfg_pref_en), .cfg_pref_state(cfg_pref_state),
        .flush_start(flush_start), .flush_done(flush_done), .op_done(op_done),
        .mode_en_wr(mode_en_wr), .irq_en(irq_en), .cm_disable(cm_disable),
        .irq_ack(irq_ack), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // Fields: [10] op_done [9:5] mode writes [4] irq_en [3] cm_disable
    //         [2] irq_ack [1] expected flag [0] expected irq
    localparam logic [10:0] VEC [0:11] = '{
        {1'b1, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b0, 5'b00000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b1, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b0, 5'b00100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 5'b00000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b0, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 5'b10000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 5'b00001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    // Record one comparison and report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One read cycle; returns the word and checks the zero positions (R1).
    task automatic rd_status(output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        @(posedge clk); #1;
        v = rd_data;
        chk("R1", "reserved bits", 32'(v & 16'hFFEC), 32'h0);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Pulse a set of inputs for one cycle.
    task automatic pulse(input logic d, input logic fs, input logic fd,
                         input logic s, input logic c);
        @(negedge clk);
        op_done = d; flush_start = fs; flush_done = fd; sw_rst = s; cop_rst = c;
        @(posedge clk); #1;
        @(negedge clk);
        op_done = 1'b0; flush_start = 1'b0; flush_done = 1'b0;
        sw_rst = 1'b0; cop_rst = 1'b0;
    endtask

    // Start a pass and check every write plus the pass length.
    task automatic run_init(input logic [3:0] k, input logic pen,
                            input logic [7:0] pst, input int exp_n,
                            input string req);
        int cnt;
        logic [15:0] v;
        @(negedge clk);
        cfg_k = k; cfg_pref_en = pen; cfg_pref_state = pst; init_start = 1'b1;
        @(posedge clk); #1;
        cnt = 0;
        while (mem_we && cnt < 600) begin
            chk("R4", "address", 32'(mem_addr), 32'(cnt));
            chk("R6", "metric", 32'(mem_wdata),
                (pen && (cnt != int'(pst))) ? 32'd64 : 32'd0);
            cnt++;
            @(negedge clk);
            init_start = 1'b0;
            @(posedge clk); #1;
        end
        chk(req, "pass length", 32'(cnt), 32'(exp_n));
        rd_status(v);
        chk("R4", "init flag after pass", 32'(v[0]), 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v;
        rst_n = 1'b0; sw_rst = 1'b0; cop_rst = 1'b0; idle = 1'b0;
        init_start = 1'b0; cfg_k = 4'd5; cfg_pref_en = 1'b0; cfg_pref_state = '0;
        flush_start = 1'b0; flush_done = 1'b0; op_done = 1'b0;
        mode_en_wr = '0; irq_en = 1'b0; cm_disable = 1'b0; irq_ack = 1'b0;
        rd_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        rd_status(v);
        chk("R2", "status after reset", 32'(v), 32'h0);
        chk("R2", "irq after reset", 32'(irq), 32'h0);
        chk("R2", "mem_we after reset", 32'(mem_we), 32'h0);

        // Table walk of completion-flag rules (R8, R9, R10)
        for (int i = 0; i < 12; i++) begin
            string req;
            logic [10:0] e;
            e = VEC[i];
            req = e[2] ? "R9" : (e[3] ? "R10" : ((|e[9:5]) ? "R8" : "R9"));
            @(negedge clk);
            op_done = e[10]; mode_en_wr = e[9:5]; irq_en = e[4];
            cm_disable = e[3]; irq_ack = e[2];
            @(posedge clk); #1;
            chk(req, $sformatf("vector %0d irq", i), 32'(irq), 32'(e[0]));
            @(negedge clk);
            op_done = 1'b0; mode_en_wr = '0; irq_ack = 1'b0;
            rd_en = 1'b1;
            @(posedge clk); #1;
            chk(req, $sformatf("vector %0d flag", i), 32'(rd_data[4]), 32'(e[1]));
            chk("R1", "reserved bits", 32'(rd_data & 16'hFFEC), 32'h0);
            @(negedge clk);
            rd_en = 1'b0; cm_disable = 1'b0; irq_en = 1'b0;
        end

        // R1: no read strobe gives zero even with a flag set
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        chk("R1", "idle read data", 32'(rd_data), 32'h0);

        // R7: flush set, clear, and collision
        pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        rd_status(v);
        chk("R7", "flush set", 32'(v[1]), 32'h1);
        chk("R1", "flag positions", 32'(v), 32'h12);
        pulse(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        rd_status(v);
        chk("R7", "done wins over start", 32'(v[1]), 32'h0);

        // R3: idle clears flush but keeps the completion flag
        pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        idle = 1'b0;
        rd_status(v);
        chk("R3", "flush cleared by idle", 32'(v[1]), 32'h0);
        chk("R3", "completion kept in idle", 32'(v[4]), 32'h1);

        // R2: software reset and coprocessor reset clear everything
        pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        rd_status(v);
        chk("R2", "software reset", 32'(v), 32'h0);
        pulse(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        rd_status(v);
        chk("R2", "coprocessor reset", 32'(v), 32'h0);

        // R4, R5, R6: passes for several state counts
        run_init(4'd5, 1'b0, 8'd0, 16, "R4");
        run_init(4'd7, 1'b1, 8'd5, 64, "R4");
        run_init(4'd9, 1'b1, 8'd200, 256, "R4");
        run_init(4'd3, 1'b0, 8'd0, 16, "R5");
        run_init(4'd15, 1'b1, 8'd0, 256, "R5");

        // R4: the flag reads one partway through a pass
        @(negedge clk);
        cfg_k = 4'd6; cfg_pref_en = 1'b0; init_start = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        init_start = 1'b0;
        rd_status(v);
        chk("R4", "init flag mid pass", 32'(v[0]), 32'h1);
        repeat (70) @(posedge clk);
        #1;
        chk("R4", "pass over", 32'(mem_we), 32'h0);

        // R3: idle aborts a pass; completion flag survives
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        cfg_k = 4'd7; init_start = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        init_start = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        idle = 1'b1;
        @(posedge clk); #1;
        chk("R3", "writes stop in idle", 32'(mem_we), 32'h0);
        @(negedge clk);
        idle = 1'b0;
        rd_status(v);
        chk("R3", "init flag after abort", 32'(v[0]), 32'h0);
        chk("R3", "completion after abort", 32'(v[4]), 32'h1);

        // R2: software reset stops a running pass
        @(negedge clk);
        init_start = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        init_start = 1'b0; sw_rst = 1'b1;
        @(posedge clk); #1;
        chk("R2", "writes stop on reset", 32'(mem_we), 32'h0);
        @(negedge clk);
        sw_rst = 1'b0;

        // R2: hardware reset clears a set completion flag
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
        rd_status(v);
        chk("R2", "hardware reset", 32'(v), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule